// File: doc/BRIEF.md
# Serial Receiver Status and Flag Unit

This block holds the status side of an asynchronous serial receiver. A separate receive shifter reports each finished character as a one-cycle pulse that carries the data and a noise indication. This unit keeps the received character in a data register and maintains four flags: data-ready, idle-line, overrun and noise. It also watches the oversampled receive line, using a bit-time tick, to find an idle line.

A bus reader clears the flags with a two-step sequence. It reads the status register first, then the data-low register. An interrupt request combines the flags under two enables: one for receive events and one for the idle line. A receiver-wakeup input keeps the idle flag from setting. A frame-length input selects 8-bit or 9-bit characters.

Top module: `uart_rx_status`

## Requirements
- R1: On a `frame_done` pulse while data-ready is 0, the data register loads `frame_data` and data-ready is 1 from the next cycle. Synchronous reset clears all four flags and `irq`.
- R2: On a `frame_done` pulse while data-ready is 1, the overrun flag sets. The data register keeps its old contents and the new character is discarded.
- R3: The noise flag sets in the same cycle as data-ready when `frame_noise` accompanies an accepted frame. It never sets for a frame that causes an overrun.
- R4: The idle flag sets on the 10th consecutive `baud_tick` with `rx_line` high when `len9` is 0, and on the 11th when `len9` is 1. Any cycle with `rx_line` low restarts the count.
- R5: While `wake_mode` is 1, an idle line never sets the idle flag.
- R6: Idle detection is armed only by an accepted frame. Arming is absent after reset and is consumed when the idle flag sets, so the idle flag cannot set again until a new frame has set data-ready.
- R7: A flag clears only when a data-low read follows a status read. A data-low read with no status read before it clears nothing.
- R8: The data-low read clears only the flags that were 1 at the preceding status read. A flag that sets between the two reads stays set.
- R9: One cycle after the flags change, `irq` equals (`rx_ie` AND (data-ready OR overrun)) OR (`idle_ie` AND idle).
- R10: A data-high read returns the ninth data bit in bit 0 if `len9` was 1 when the character was loaded. Otherwise it returns zero.
- R11: Reads use these addresses: `rd_addr` 0 is status, 1 is data-high and 2 is data-low. `rd_data` is valid one cycle after `rd_en`. The status byte has data-ready in bit 0, idle in bit 1, overrun in bit 2, noise in bit 3, and zeros in bits 7 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One pulse per bit time |
| rx_line | input | 1 | Receive line level |
| len9 | input | 1 | 1 selects 9-bit characters |
| wake_mode | input | 1 | Receiver wakeup; blocks the idle flag |
| rx_ie | input | 1 | Interrupt enable for data-ready and overrun |
| idle_ie | input | 1 | Interrupt enable for idle |
| frame_done | input | 1 | One-cycle pulse for a finished character |
| frame_noise | input | 1 | Noise was seen in the finished character |
| frame_data | input | 9 | Character from the shifter |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, registered |
| irq | output | 1 | Interrupt request, registered |

## Verification
The assertions assume that `frame_done` is a single-cycle pulse and that `rd_en` never coincides with a frame that changes the register being read. They also assume that `rx_line` stays high during idle counting unless a restart is intended. The stimulus meets these assumptions by driving every input on the falling edge and by separating frames and reads by at least one full cycle. It holds `rx_line` high apart from deliberate one-cycle low pulses and raises `baud_tick` only inside the idle-counting sequences.

// File: rtl/uart_rx_status_pkg.sv
package uart_rx_status_pkg;
  localparam int FL_READY = 0;
  localparam int FL_IDLE  = 1;
  localparam int FL_OVR   = 2;
  localparam int FL_NOISE = 3;
  localparam int NUM_FL   = 4;
  typedef enum logic [1:0] {
    ADDR_STAT = 2'd0,
    ADDR_DHI  = 2'd1,
    ADDR_DLO  = 2'd2
  } rd_addr_e;
endpackage

// File: rtl/rx_idle_detect.sv
module rx_idle_detect #(
  parameter int IDLE_SHORT = 10,
  parameter int IDLE_LONG  = 11,
  localparam int CNT_W = $clog2(IDLE_LONG + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic baud_tick,
  input  logic rx_line,
  input  logic len9,
  output logic idle_hit
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit    = len9 ? CNT_W'(IDLE_LONG) : CNT_W'(IDLE_SHORT);
  assign idle_hit = baud_tick && rx_line && (cnt == limit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !rx_line) cnt <= '0;
    else if (baud_tick && cnt < limit) cnt <= cnt + CNT_W'(1);
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(IDLE_LONG));
  // R4
  low_restart_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_line |=> cnt == '0);
endmodule

// File: rtl/rx_flag_ctrl.sv
module rx_flag_ctrl
  import uart_rx_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_FL-1:0] set_v,
  input  logic              stat_rd,
  input  logic              dlo_rd,
  output logic [NUM_FL-1:0] flags
);
  logic [NUM_FL-1:0] armed;
  logic [NUM_FL-1:0] clr;

  assign clr = dlo_rd ? armed : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      armed <= '0;
    end else begin
      flags <= (flags & ~clr) | set_v;
      if (stat_rd) armed <= flags;
      else if (dlo_rd) armed <= '0;
    end
  end

  // R7
  no_clr_without_read_chk: assert property (@(posedge clk) disable iff (rst)
    !dlo_rd |=> ((flags & $past(flags)) == $past(flags)));
  // R8
  armed_subset_chk: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> ((armed & ~$past(flags)) == '0));
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_status_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int IDLE_SHORT = 10,
  parameter int IDLE_LONG  = 11,
  localparam int FRAME_W   = DATA_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               baud_tick,
  input  logic               rx_line,
  input  logic               len9,
  input  logic               wake_mode,
  input  logic               rx_ie,
  input  logic               idle_ie,
  input  logic               frame_done,
  input  logic               frame_noise,
  input  logic [FRAME_W-1:0] frame_data,
  input  logic               rd_en,
  input  logic [1:0]         rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               irq
);
  logic [NUM_FL-1:0] flags;
  logic [NUM_FL-1:0] set_v;
  logic [DATA_W-1:0] data_lo;
  logic              data_hi;
  logic              idle_hit;
  logic              idle_armed;
  logic              accept;
  logic              idle_set;
  logic              stat_rd;
  logic              dlo_rd;

  assign stat_rd  = rd_en && rd_addr == ADDR_STAT;
  assign dlo_rd   = rd_en && rd_addr == ADDR_DLO;
  assign accept   = frame_done && !flags[FL_READY];
  assign idle_set = idle_hit && idle_armed && !wake_mode;

  always_comb begin
    set_v           = '0;
    set_v[FL_READY] = accept;
    set_v[FL_NOISE] = accept && frame_noise;
    set_v[FL_OVR]   = frame_done && flags[FL_READY];
    set_v[FL_IDLE]  = idle_set;
  end

  rx_idle_detect #(.IDLE_SHORT(IDLE_SHORT), .IDLE_LONG(IDLE_LONG)) u_idle (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .rx_line(rx_line),
    .len9(len9), .idle_hit(idle_hit)
  );

  rx_flag_ctrl u_flags (
    .clk(clk), .rst(rst), .set_v(set_v), .stat_rd(stat_rd),
    .dlo_rd(dlo_rd), .flags(flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_lo    <= '0;
      data_hi    <= 1'b0;
      idle_armed <= 1'b0;
      rd_data    <= '0;
      irq        <= 1'b0;
    end else begin
      if (accept) begin
        data_lo <= frame_data[DATA_W-1:0];
        data_hi <= len9 && frame_data[DATA_W];
      end
      if (accept) idle_armed <= 1'b1;
      else if (idle_set) idle_armed <= 1'b0;
      if (rd_en) begin
        case (rd_addr)
          ADDR_STAT: rd_data <= DATA_W'(flags);
          ADDR_DHI:  rd_data <= DATA_W'(data_hi);
          ADDR_DLO:  rd_data <= data_lo;
          default:   rd_data <= '0;
        endcase
      end
      irq <= (rx_ie && (flags[FL_READY] || flags[FL_OVR])) ||
             (idle_ie && flags[FL_IDLE]);
    end
  end

  // R2
  ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done && flags[FL_READY] |=> $stable(data_lo) && flags[FL_OVR]);
  // R3
  no_noise_on_ovr_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done && flags[FL_READY] && !flags[FL_NOISE] |=> !flags[FL_NOISE]);
  // R1
  ready_needs_frame_chk: assert property (@(posedge clk) disable iff (rst)
    !flags[FL_READY] && !frame_done |=> !flags[FL_READY]);
  // R5
  wake_blocks_idle_chk: assert property (@(posedge clk) disable iff (rst)
    wake_mode && !flags[FL_IDLE] |=> !flags[FL_IDLE]);
  // R9
  rx_irq_chk: assert property (@(posedge clk) disable iff (rst)
    rx_ie && flags[FL_READY] |=> irq);
endmodule

// File: tb/tb_uart_rx_status.sv
module tb_uart_rx_status;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0, rx_line = 1'b1, len9 = 1'b0, wake_mode = 1'b0;
  logic       rx_ie = 1'b0, idle_ie = 1'b0, frame_done = 1'b0, frame_noise = 1'b0;
  logic [8:0] frame_data = '0;
  logic       rd_en = 1'b0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       irq;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  uart_rx_status dut (.*);

  // len9, noise, data9, exp data-low, exp data-high, exp status
  localparam int NV = 6;
  localparam logic [30:0] VEC [NV] = '{
    {1'b0, 1'b0, 9'h03C, 8'h3C, 8'h00, 4'h1},
    {1'b0, 1'b1, 9'h0FF, 8'hFF, 8'h00, 4'h9},
    {1'b1, 1'b0, 9'h1A5, 8'hA5, 8'h01, 4'h1},
    {1'b1, 1'b1, 9'h100, 8'h00, 8'h01, 4'h9},
    {1'b0, 1'b0, 9'h1A5, 8'hA5, 8'h00, 4'h1},
    {1'b1, 1'b0, 9'h07E, 8'h7E, 8'h00, 4'h1}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic send(input logic [8:0] d, input logic nz);
    frame_data = d; frame_noise = nz; frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0; frame_noise = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      baud_tick = 1'b1;
      @(negedge clk);
    end
    baud_tick = 1'b0;
  endtask

  task automatic line_low();
    rx_line = 1'b0;
    @(negedge clk);
    rx_line = 1'b1;
  endtask

  task automatic clear_all();
    logic [7:0] v;
    rd(2'd0, v);
    rd(2'd2, v);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset irq", {7'b0, irq}, 8'h00);
    rd(2'd0, v); check("R1 R11 reset status", v, 8'h00);

    for (int i = 0; i < NV; i++) begin
      len9 = VEC[i][30];
      send(VEC[i][28:20], VEC[i][29]);
      rd(2'd0, v); check("R1 R3 R11 table status", v, {4'h0, VEC[i][3:0]});
      rd(2'd1, v); check("R10 table data-high", v, VEC[i][11:4]);
      rd(2'd2, v); check("R1 table data-low", v, VEC[i][19:12]);
      rd(2'd0, v); check("R7 table cleared", v, 8'h00);
    end
    len9 = 1'b0;

    // overrun with noisy second frame
    send(9'h05A, 1'b0);
    send(9'h0C3, 1'b1);
    rd(2'd0, v); check("R2 R3 overrun status", v, 8'h05);
    rd(2'd2, v); check("R2 data kept", v, 8'h5A);
    rd(2'd0, v); check("R7 overrun cleared", v, 8'h00);

    // wrong order
    send(9'h011, 1'b0);
    rd(2'd2, v); check("R7 data-low first", v, 8'h11);
    rd(2'd0, v); check("R7 no clear wrong order", v, 8'h01);
    rd(2'd2, v);
    rd(2'd0, v); check("R7 clear after sequence", v, 8'h00);

    // flag set between reads
    send(9'h022, 1'b0);
    rd(2'd0, v);
    send(9'h033, 1'b0);
    rd(2'd2, v); check("R8 data", v, 8'h22);
    rd(2'd0, v); check("R8 overrun survives", v, 8'h04);
    clear_all();

    // interrupt routing
    rx_ie = 1'b1;
    send(9'h044, 1'b0);
    @(negedge clk);
    check("R9 rx irq", {7'b0, irq}, 8'h01);
    clear_all();
    @(negedge clk);
    check("R9 irq drops", {7'b0, irq}, 8'h00);
    rx_ie = 1'b0;

    // idle, 8-bit length
    idle_ie = 1'b1;
    send(9'h055, 1'b0);
    clear_all();
    line_low();
    ticks(9);
    rd(2'd0, v); check("R4 no idle at 9", v, 8'h00);
    line_low();
    ticks(9);
    rd(2'd0, v); check("R4 low restarts", v, 8'h00);
    ticks(1);
    rd(2'd0, v); check("R4 idle at 10", v, 8'h02);
    check("R9 idle irq", {7'b0, irq}, 8'h01);
    rd(2'd2, v);
    rd(2'd0, v); check("R7 idle cleared", v, 8'h00);
    line_low();
    ticks(12);
    rd(2'd0, v); check("R6 no rearm without frame", v, 8'h00);
    idle_ie = 1'b0;

    // idle, 9-bit length
    len9 = 1'b1;
    send(9'h066, 1'b0);
    clear_all();
    line_low();
    ticks(10);
    rd(2'd0, v); check("R4 no idle at 10 long", v, 8'h00);
    ticks(1);
    rd(2'd0, v); check("R4 R6 idle at 11 long", v, 8'h02);
    rd(2'd2, v);
    len9 = 1'b0;

    // wakeup blocks idle
    send(9'h077, 1'b0);
    clear_all();
    wake_mode = 1'b1;
    line_low();
    ticks(12);
    rd(2'd0, v); check("R5 wake blocks idle", v, 8'h00);
    wake_mode = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule